// File: doc/BRIEF.md
# Floating-Point Exception Status Accumulator

This block is the status-register slice that surrounds every floating-point operation. A start pulse marks the beginning of an operation. On that pulse the block clears its record of exceptions for the operation and turns the 2-bit rounding field into a one-hot rounding-mode vector for the arithmetic datapath. The block holds that vector until the next start pulse.

While an operation runs, the datapath may raise any of five exception kinds, on any cycle and as often as it likes. The block ORs each raise into a pending record. An end pulse then merges the record into the sticky status bits. A trap is requested only for an exception whose sticky bit goes from 0 to 1 while its enable bit is set. A sticky bit that is already set absorbs further raises silently. Software can write the sticky and enable fields directly, and such a write wins over the end-of-operation update in the same cycle.

Top module: `fp_status_acc`

## Requirements
- R1: After reset the sticky field, the enable field, `trap_req` and `trap_cause` are all zero, and `rnd_onehot` is 4'b0001.
- R2: In the cycle after `op_start`, `rnd_onehot` shows the decoded rounding field with exactly one bit set. Field value 0 sets bit 0 (nearest-even), 1 sets bit 1 (toward zero), 2 sets bit 2 (toward minus infinity) and 3 sets bit 3 (toward plus infinity). The value holds until the next `op_start`.
- R3: Every 5-bit flag vector uses the same bit order: bit 0 inexact, bit 1 divide-by-zero, bit 2 invalid, bit 3 overflow, bit 4 underflow. This applies to `flag_raise`, the sticky field, the enable field, the software write data and `trap_cause`.
- R4: The pending record collects raises seen after an `op_start` cycle, up to and including the `op_end` cycle. A kind raised several times counts once. Raises that arrive in the `op_start` cycle itself are discarded.
- R5: In the cycle after `op_end`, each sticky bit equals its old value ORed with the pending record.
- R6: In the cycle after `op_end`, `trap_req` is 1 exactly when some pending bit had a sticky value of 0 and an enable value of 1. `trap_cause` holds those bits.
- R7: A pending kind whose sticky bit is already 1 causes no trap and no change.
- R8: An `op_end` with an empty pending record leaves the sticky field unchanged and raises no trap.
- R9: A software write to the sticky or enable field shows on the next cycle and overrides the end-step update in that cycle. The trap decision in that same cycle uses the values from before the write.
- R10: `trap_req` is a one-cycle pulse. It falls in the cycle after it rises unless another `op_end` raises it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | Operation start pulse |
| op_end | input | 1 | Operation end pulse |
| rnd_field | input | 2 | Rounding-mode field, sampled on `op_start` |
| flag_raise | input | 5 | Exceptions raised by the datapath this cycle |
| sw_wr_sticky | input | 1 | Software write strobe for the sticky field |
| sw_sticky_data | input | 5 | Data for the sticky write |
| sw_wr_enable | input | 1 | Software write strobe for the enable field |
| sw_enable_data | input | 5 | Data for the enable write |
| rnd_onehot | output | 4 | One-hot rounding mode for the datapath |
| sticky | output | 5 | Sticky exception status bits |
| enable | output | 5 | Per-kind trap enable bits |
| trap_req | output | 1 | Trap request pulse |
| trap_cause | output | 5 | Kinds that newly set with their enable on |

## Verification
Every result of this block comes one register stage after its stimulus. The rounding vector, the sticky and enable fields, `trap_req` and `trap_cause` all change on the first rising edge after the cycle that carries `op_start`, `op_end` or a software write. A driver task applies one cycle of stimulus at the falling edge. In the same step it pushes the outputs a requirement-level model expects after the next rising edge. A monitor pops one item two nanoseconds after each rising edge and compares all five outputs, so each expectation is checked in exactly the cycle it is due.

// File: rtl/fp_status_acc.sv
module fp_status_acc #(
  parameter int NFLAG = 5,
  parameter int RW    = 2,
  localparam int NMODE = 1 << RW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_start,
  input  logic             op_end,
  input  logic [RW-1:0]    rnd_field,
  input  logic [NFLAG-1:0] flag_raise,
  input  logic             sw_wr_sticky,
  input  logic [NFLAG-1:0] sw_sticky_data,
  input  logic             sw_wr_enable,
  input  logic [NFLAG-1:0] sw_enable_data,
  output logic [NMODE-1:0] rnd_onehot,
  output logic [NFLAG-1:0] sticky,
  output logic [NFLAG-1:0] enable,
  output logic             trap_req,
  output logic [NFLAG-1:0] trap_cause
);

  logic [NFLAG-1:0] pend;
  logic [NFLAG-1:0] merged;
  logic [NFLAG-1:0] fresh;

  assign merged = pend | flag_raise;
  assign fresh  = merged & ~sticky;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
    end else if (op_start || op_end) begin
      pend <= '0;
    end else begin
      pend <= merged;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rnd_onehot <= NMODE'(1);
    end else if (op_start) begin
      rnd_onehot <= NMODE'(1) << rnd_field;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky <= '0;
    end else if (sw_wr_sticky) begin
      sticky <= sw_sticky_data;
    end else if (op_end) begin
      sticky <= sticky | merged;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable <= '0;
    end else if (sw_wr_enable) begin
      enable <= sw_enable_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_cause <= '0;
      trap_req   <= 1'b0;
    end else if (op_end) begin
      trap_cause <= fresh & enable;
      trap_req   <= |(fresh & enable);
    end else begin
      trap_cause <= '0;
      trap_req   <= 1'b0;
    end
  end

endmodule

module fp_status_acc_chk #(
  parameter int NFLAG = 5,
  parameter int RW    = 2,
  localparam int NMODE = 1 << RW
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_start,
  input logic             op_end,
  input logic [RW-1:0]    rnd_field,
  input logic [NFLAG-1:0] flag_raise,
  input logic             sw_wr_sticky,
  input logic [NFLAG-1:0] sw_sticky_data,
  input logic             sw_wr_enable,
  input logic [NFLAG-1:0] sw_enable_data,
  input logic [NMODE-1:0] rnd_onehot,
  input logic [NFLAG-1:0] sticky,
  input logic [NFLAG-1:0] enable,
  input logic             trap_req,
  input logic [NFLAG-1:0] trap_cause
);

  AST_RND_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $countones(rnd_onehot) == 1); // R2
  AST_RND_DECODE: assert property (@(posedge clk) disable iff (!rst_n) op_start |=> rnd_onehot[$past(rnd_field)]); // R2
  AST_END_MERGES_RAISE: assert property (@(posedge clk) disable iff (!rst_n) (op_end && !sw_wr_sticky) |=> (sticky & $past(flag_raise)) == $past(flag_raise)); // R5
  AST_CAUSE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n) trap_req |-> (trap_cause & ~$past(enable)) == '0); // R6
  AST_TRAP_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n) trap_req |-> $past(op_end)); // R6
  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n) trap_req |-> (trap_cause & $past(sticky)) == '0); // R7
  AST_STICKY_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (!op_end && !sw_wr_sticky) |=> $stable(sticky)); // R8
  AST_SW_WINS: assert property (@(posedge clk) disable iff (!rst_n) sw_wr_sticky |=> sticky == $past(sw_sticky_data)); // R9
  AST_TRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (trap_req && !op_end) |=> !trap_req); // R10

endmodule

bind fp_status_acc fp_status_acc_chk #(.NFLAG(NFLAG), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_end(op_end),
  .rnd_field(rnd_field), .flag_raise(flag_raise),
  .sw_wr_sticky(sw_wr_sticky), .sw_sticky_data(sw_sticky_data),
  .sw_wr_enable(sw_wr_enable), .sw_enable_data(sw_enable_data),
  .rnd_onehot(rnd_onehot), .sticky(sticky), .enable(enable),
  .trap_req(trap_req), .trap_cause(trap_cause)
);

// File: tb/sim_fp_status_acc.sv
`timescale 1ns/1ps
module sim_fp_status_acc;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_start = 1'b0, op_end = 1'b0;
  logic [1:0] rnd_field = 2'd0;
  logic [4:0] flag_raise = '0;
  logic       sw_wr_sticky = 1'b0, sw_wr_enable = 1'b0;
  logic [4:0] sw_sticky_data = '0, sw_enable_data = '0;
  logic [3:0] rnd_onehot;
  logic [4:0] sticky, enable, trap_cause;
  logic       trap_req;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fp_status_acc u0 (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_end(op_end),
    .rnd_field(rnd_field), .flag_raise(flag_raise),
    .sw_wr_sticky(sw_wr_sticky), .sw_sticky_data(sw_sticky_data),
    .sw_wr_enable(sw_wr_enable), .sw_enable_data(sw_enable_data),
    .rnd_onehot(rnd_onehot), .sticky(sticky), .enable(enable),
    .trap_req(trap_req), .trap_cause(trap_cause)
  );

  typedef struct {
    logic [3:0] rnd;
    logic [4:0] stk;
    logic [4:0] en;
    logic       trap;
    logic [4:0] cause;
    string      tag;
  } exp_t;

  exp_t q[$];

  logic [3:0] m_rnd = 4'b0001;
  logic [4:0] m_stk = '0, m_en = '0, m_pend = '0;

  task automatic step(input bit st, input bit en_p, input logic [1:0] rf,
                      input logic [4:0] rs, input bit ws, input logic [4:0] sd,
                      input bit we, input logic [4:0] ed, input string tag);
    exp_t e;
    logic [4:0] mg;
    @(negedge clk);
    op_start = st; op_end = en_p; rnd_field = rf; flag_raise = rs;
    sw_wr_sticky = ws; sw_sticky_data = sd; sw_wr_enable = we; sw_enable_data = ed;
    mg = m_pend | rs;
    e.cause = en_p ? (mg & ~m_stk & m_en) : 5'd0;
    e.trap  = |e.cause;
    if (st) m_rnd = 4'b0001 << rf;
    m_stk  = ws ? sd : (en_p ? (m_stk | mg) : m_stk);
    m_en   = we ? ed : m_en;
    m_pend = (st || en_p) ? 5'd0 : mg;
    e.rnd = m_rnd; e.stk = m_stk; e.en = m_en; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 2'd0, 5'd0, 0, 5'd0, 0, 5'd0, tag);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        total++;
        if (rnd_onehot !== e.rnd || sticky !== e.stk || enable !== e.en ||
            trap_req !== e.trap || trap_cause !== e.cause) begin
          bad++;
          $display("FAIL %s: got rnd=%b stk=%b en=%b trap=%b cause=%b exp rnd=%b stk=%b en=%b trap=%b cause=%b",
                   e.tag, rnd_onehot, sticky, enable, trap_req, trap_cause,
                   e.rnd, e.stk, e.en, e.trap, e.cause);
        end
      end
    end
  end

  initial begin : watchdog
    #(8 * 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    total++;
    if (sticky !== 5'd0 || enable !== 5'd0 || trap_req !== 1'b0 ||
        trap_cause !== 5'd0 || rnd_onehot !== 4'b0001) begin
      bad++;
      $display("FAIL R1: got stk=%b en=%b trap=%b cause=%b rnd=%b exp 00000 00000 0 00000 0001",
               sticky, enable, trap_req, trap_cause, rnd_onehot);
    end

    // R2: each rounding code, held while idle
    for (int k = 0; k < 4; k++) begin
      step(1, 0, 2'(k), 5'd0, 0, 5'd0, 0, 5'd0, "R2 decode");
      idle("R2 hold");
    end
    step(0, 0, 2'd2, 5'd0, 0, 5'd0, 0, 5'd0, "R2 field ignored without start");

    // enable everything
    step(0, 0, 2'd0, 5'd0, 0, 5'd0, 1, 5'b11111, "R9 enable write");

    // R3/R5/R6: divide-by-zero (bit 1) traps
    step(1, 0, 2'd0, 5'd0, 0, 5'd0, 0, 5'd0, "R4 start");
    step(0, 0, 2'd0, 5'b00010, 0, 5'd0, 0, 5'd0, "R3 raise dbz");
    step(0, 1, 2'd0, 5'd0, 0, 5'd0, 0, 5'd0, "R6 dbz trap");
    idle("R10 trap falls");

    // R7: already set, no trap
    step(1, 0, 2'd1, 5'd0, 0, 5'd0, 0, 5'd0, "R4 start");
    step(0, 0, 2'd0, 5'b00010, 0, 5'd0, 0, 5'd0, "R7 raise again");
    step(0, 1, 2'd0, 5'b00010, 0, 5'd0, 0, 5'd0, "R7 no retrigger");

    // R4: repeated inexact plus overflow on end cycle
    step(1, 0, 2'd0, 5'd0, 0, 5'd0, 0, 5'd0, "R4 start");
    step(0, 0, 2'd0, 5'b00001, 0, 5'd0, 0, 5'd0, "R4 raise");
    step(0, 0, 2'd0, 5'b00001, 0, 5'd0, 0, 5'd0, "R4 raise twice");
    step(0, 1, 2'd0, 5'b01000, 0, 5'd0, 0, 5'd0, "R4 merged trap");
    // back-to-back end: nothing pending, no trap
    step(0, 1, 2'd0, 5'd0, 0, 5'd0, 0, 5'd0, "R10 second end");

    // R4: raise in start cycle discarded; R8 empty end
    step(1, 0, 2'd0, 5'b00100, 0, 5'd0, 0, 5'd0, "R4 start raise dropped");
    step(0, 1, 2'd0, 5'd0, 0, 5'd0, 0, 5'd0, "R8 empty end");

    // R6: underflow disabled -> sticky sets, no trap
    step(0, 0, 2'd0, 5'd0, 0, 5'd0, 1, 5'b01111, "R9 enable write");
    step(1, 0, 2'd0, 5'd0, 0, 5'd0, 0, 5'd0, "R4 start");
    step(0, 1, 2'd0, 5'b10000, 0, 5'd0, 0, 5'd0, "R6 disabled no trap");

    // R9: software clear wins over end, trap uses old sticky
    step(1, 0, 2'd0, 5'd0, 0, 5'd0, 0, 5'd0, "R4 start");
    step(0, 1, 2'd0, 5'b00110, 1, 5'd0, 0, 5'd0, "R9 sticky write wins");
    step(1, 0, 2'd0, 5'd0, 0, 5'd0, 0, 5'd0, "R4 start");
    step(0, 1, 2'd0, 5'b00100, 0, 5'd0, 0, 5'd0, "R9 retrap after clear");

    // R9: enable write same cycle as end uses old enable
    step(0, 0, 2'd0, 5'd0, 1, 5'd0, 0, 5'd0, "R9 clear sticky");
    step(1, 0, 2'd0, 5'd0, 0, 5'd0, 0, 5'd0, "R4 start");
    step(0, 1, 2'd0, 5'b10001, 0, 5'd0, 1, 5'b10000, "R9 old enable used");
    step(1, 0, 2'd3, 5'd0, 0, 5'd0, 0, 5'd0, "R4 start");
    step(0, 1, 2'd0, 5'b01000, 0, 5'd0, 0, 5'd0, "R9 new enable applies");
    idle("R10 idle");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule